// File: doc/BRIEF.md
# Unified Address Translation Buffer with Protection Checks

This block is a fully associative translation buffer for data accesses. Each entry holds a virtual page number, an address-space identifier, a physical page number and a flag word. The flag word sets the page size (1 KB, 4 KB, 64 KB or 1 MB), the valid, shared, user, writable and dirty attributes, and two attributes that the block stores but does not act on. Software fills the buffer through two staging registers. The entry-high register holds the page number and the identifier. The entry-low register holds the physical page and the flags. A load strobe then copies both registers into the slot that a replacement counter points at. The counter moves forward by one on every lookup and wraps at a programmable boundary.

For each request the block takes a virtual address, a privilege bit, a read/write bit, a single-virtual-space bit and the current identifier. One cycle later it gives a registered answer, which is either a physical address or exactly one fault flag. On any fault, the block captures the full virtual address in a fault-address register. It also writes the faulting page number into the entry-high staging register and leaves that register's low ten bits as they were. Refill software can then use the staged value directly.

Top module: `utlb_xlate`

## Requirements
- R1: Flag bits 7 and 4 (in that order) select the page size: 00 = 1 KB, 01 = 4 KB, 10 = 64 KB, 11 = 1 MB. The page compare and the physical page field use address bits 31:10, 31:12, 31:16 or 31:20 respectively, and the remaining low bits come unchanged from the virtual address.
- R2: An entry matches only when its valid flag (bit 8) is set, its page number equals the address under its size mask, and either its shared flag (bit 1) is set or its stored identifier equals the current identifier.
- R3: When the single-virtual-space input and the privilege input are both high, the identifier comparison is skipped. In every other combination it is applied.
- R4: A lookup with no matching entry reports a read miss (fault bit 0) for a read or a write miss (fault bit 1) for a write.
- R5: A lookup that matches more than one entry reports a multi-hit (fault bit 2), whatever the access type.
- R6: An unprivileged read of a matched entry whose user flag (bit 6) is clear reports a read protection fault (fault bit 3).
- R7: A privileged write needs the writable flag (bit 5). An unprivileged write needs both the writable and the user flags. Otherwise the lookup reports a write protection fault (fault bit 4).
- R8: A write that passes the protection checks but matches an entry whose dirty flag (bit 2) is clear reports an initial-write fault (fault bit 5).
- R9: The entry-low staging register keeps only bits 28:10 and 8:0 of a written word. The entry-high staging register keeps only bits 31:10 and 7:0. As a result, translated addresses never have bits 31:29 set.
- R10: The replacement counter starts at 0 and moves forward by one on every lookup. When the next value would equal the programmed boundary or the entry count, it becomes 0 instead. A load writes the slot the counter currently names.
- R11: On any fault, the fault-address output captures the full virtual address, and bits 31:10 of the entry-high staging register take the address's bits 31:10 while bits 9:0 are kept. A fault takes precedence over a staging write in the same cycle.
- R12: The response is valid exactly one cycle after a request. At most one fault bit is set. The physical address reads zero whenever a fault is reported.
- R13: A global invalidate clears every valid flag in one cycle and takes precedence over a load in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inv_all | input | 1 | Clear all valid flags |
| stg_hi_we | input | 1 | Write entry-high staging register |
| stg_lo_we | input | 1 | Write entry-low staging register |
| stg_wdata | input | 32 | Staging write data |
| load_en | input | 1 | Copy staging registers into the counter's slot |
| bound_we | input | 1 | Write replacement boundary |
| bound_wdata | input | IDX_W | Replacement boundary value |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address |
| req_priv | input | 1 | Privileged access |
| req_write | input | 1 | Write access (0 = read) |
| req_sv | input | 1 | Single-virtual-space mode |
| cur_asid | input | 8 | Current address-space identifier |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| rsp_fault | output | 6 | One-hot fault flags |
| fault_vaddr | output | 32 | Last faulting virtual address |
| repl_idx | output | IDX_W | Replacement counter value |
| stage_hi | output | 32 | Entry-high staging register |

## Verification
The assertions check several properties on every cycle. A response carries at most one fault flag, and any fault comes with a zero physical address. The captured fault address agrees with the staged page number. The replacement counter either holds or steps by one (or to zero). An invalidate leaves no valid entry behind. The order in which faults take priority, the page-size masks, the identifier bypass and the exact wrap point of the counter depend on the contents of the table and on the history of requests. Only the bench scenarios can show these, because they load known entries and compare whole responses against values worked out from the requirements.

// File: rtl/vxt_pkg.sv
package vxt_pkg;
  localparam int VA_W    = 32;
  localparam int ASID_W  = 8;
  localparam int PG_LSB  = 10;
  localparam int VPN_W   = VA_W - PG_LSB;
  localparam int PPN_MSB = 28;
  localparam int PPN_W   = PPN_MSB - PG_LSB + 1;
  localparam int FLAG_W  = 9;

  // flag word bit positions (size bits are decoded by the compare logic)
  localparam int FB_VALID = 8;
  localparam int FB_SZ_HI = 7;
  localparam int FB_USER  = 6;
  localparam int FB_WR    = 5;
  localparam int FB_SZ_LO = 4;
  localparam int FB_DIRTY = 2;
  localparam int FB_SHARE = 1;

  // one-hot fault vector positions
  localparam int FLT_RD_MISS  = 0;
  localparam int FLT_WR_MISS  = 1;
  localparam int FLT_MULTI    = 2;
  localparam int FLT_RD_PROT  = 3;
  localparam int FLT_WR_PROT  = 4;
  localparam int FLT_FIRST_WR = 5;
  localparam int FLT_W        = 6;

  localparam logic [VA_W-1:0] HI_KEEP = 32'hFFFF_FCFF;
  localparam logic [VA_W-1:0] LO_KEEP = 32'h1FFF_FDFF;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [PPN_W-1:0]  ppn;
    logic [FLAG_W-1:0] flags;
  } tlb_ent_t;

  // page-number bits kept by the compare for each size code
  function automatic logic [VPN_W-1:0] size_mask(input logic [1:0] sz);
    int sh;
    case (sz)
      2'b00:   sh = 0;
      2'b01:   sh = 2;
      2'b10:   sh = 6;
      default: sh = 10;
    endcase
    return {VPN_W{1'b1}} << sh;
  endfunction
endpackage

// File: rtl/vxt_repl_ctr.sv
module vxt_repl_ctr #(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             bound_we,
  input  logic [IDX_W-1:0] bound_wdata,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] idx_q, bound_q;
  logic [IDX_W:0]   nxt;

  assign nxt = {1'b0, idx_q} + 1'b1;
  assign idx = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      bound_q <= '0;
    end else begin
      if (bound_we) bound_q <= bound_wdata;
      if (step) begin
        if (nxt == {1'b0, bound_q} || nxt == (IDX_W+1)'(ENTRIES)) idx_q <= '0;
        else idx_q <= nxt[IDX_W-1:0];
      end
    end
  end

  // R10: counter steps by one or wraps to zero on a lookup
  a_r10_ctr_step: assert property (@(posedge clk) disable iff (rst)
    step |=> (idx_q == '0 || idx_q == $past(idx_q) + 1'b1));
  // R10: counter holds when no lookup is made
  a_r10_ctr_hold: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(idx_q));
endmodule

// File: rtl/vxt_entry_store.sv
module vxt_entry_store
  import vxt_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inv_all,
  input  logic              load_en,
  input  logic [IDX_W-1:0]  load_idx,
  input  tlb_ent_t          load_ent,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_skip_asid,
  output logic              hit_any,
  output logic              hit_multi,
  output tlb_ent_t          hit_ent
);
  tlb_ent_t           ent_q [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [ENTRIES-1:0] vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (load_en && load_idx == IDX_W'(i)) ent_q[i] <= load_ent;
        if (inv_all) ent_q[i].flags[FB_VALID] <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [VPN_W-1:0] msk;
    assign msk = size_mask({ent_q[g].flags[FB_SZ_HI], ent_q[g].flags[FB_SZ_LO]});
    assign vld[g] = ent_q[g].flags[FB_VALID];
    assign match[g] = vld[g]
                   && (ent_q[g].flags[FB_SHARE] || lk_skip_asid || ent_q[g].asid == lk_asid)
                   && (((ent_q[g].vpn ^ lk_vpn) & msk) == '0);
  end

  // AND-OR select; a second hit flags multi-hit so the merged value is unused then
  always_comb begin
    hit_any   = 1'b0;
    hit_multi = 1'b0;
    hit_ent   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        if (hit_any) hit_multi = 1'b1;
        hit_any = 1'b1;
        hit_ent = hit_ent | ent_q[i];
      end
    end
  end

  // R13: invalidate leaves no valid entry, even with a load in the same cycle
  a_r13_inv_clears: assert property (@(posedge clk) disable iff (rst)
    inv_all |=> (vld == '0));
endmodule

// File: rtl/vxt_fault_eval.sv
module vxt_fault_eval
  import vxt_pkg::*;
(
  input  logic             hit_any,
  input  logic             hit_multi,
  input  logic [1:0]       sz,
  input  logic             f_user,
  input  logic             f_wr,
  input  logic             f_dirty,
  input  logic [PPN_W-1:0] ppn,
  input  logic [VA_W-1:0]  vaddr,
  input  logic             priv,
  input  logic             write,
  output logic [FLT_W-1:0] fault,
  output logic [VA_W-1:0]  paddr
);
  logic [VPN_W-1:0] msk, ppn_ext, pa_hi;

  assign msk     = size_mask(sz);
  assign ppn_ext = VPN_W'(ppn);
  assign pa_hi   = (ppn_ext & msk) | (vaddr[VA_W-1:PG_LSB] & ~msk);

  always_comb begin
    fault = '0;
    if (hit_multi)                      fault[FLT_MULTI] = 1'b1;
    else if (!hit_any)                  fault[write ? FLT_WR_MISS : FLT_RD_MISS] = 1'b1;
    else if (!write) begin
      if (!priv && !f_user)             fault[FLT_RD_PROT] = 1'b1;
    end
    else if (priv ? !f_wr : !(f_wr && f_user)) fault[FLT_WR_PROT] = 1'b1;
    else if (!f_dirty)                  fault[FLT_FIRST_WR] = 1'b1;
  end

  assign paddr = (fault != '0) ? '0 : {pa_hi, vaddr[PG_LSB-1:0]};
endmodule

// File: rtl/utlb_xlate.sv
module utlb_xlate
  import vxt_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inv_all,
  input  logic              stg_hi_we,
  input  logic              stg_lo_we,
  input  logic [31:0]       stg_wdata,
  input  logic              load_en,
  input  logic              bound_we,
  input  logic [IDX_W-1:0]  bound_wdata,
  input  logic              req_valid,
  input  logic [31:0]       req_vaddr,
  input  logic              req_priv,
  input  logic              req_write,
  input  logic              req_sv,
  input  logic [7:0]        cur_asid,
  output logic              rsp_valid,
  output logic [31:0]       rsp_paddr,
  output logic [5:0]        rsp_fault,
  output logic [31:0]       fault_vaddr,
  output logic [IDX_W-1:0]  repl_idx,
  output logic [31:0]       stage_hi
);
  logic [VA_W-1:0]  stg_hi_q, stg_lo_q;
  tlb_ent_t         load_ent, hit_ent;
  logic             hit_any, hit_multi;
  logic [FLT_W-1:0] flt;
  logic [VA_W-1:0]  pa;
  logic             unused_bits;

  assign load_ent.vpn   = stg_hi_q[VA_W-1:PG_LSB];
  assign load_ent.asid  = stg_hi_q[ASID_W-1:0];
  assign load_ent.ppn   = stg_lo_q[PPN_MSB:PG_LSB];
  assign load_ent.flags = stg_lo_q[FLAG_W-1:0];
  assign unused_bits = ^{stg_hi_q[9:8], stg_lo_q[31:29], stg_lo_q[9],
                         hit_ent.vpn, hit_ent.asid, hit_ent.flags[8], hit_ent.flags[3],
                         hit_ent.flags[1:0]};

  vxt_repl_ctr #(.ENTRIES(ENTRIES)) u_ctr (
    .clk(clk), .rst(rst), .step(req_valid),
    .bound_we(bound_we), .bound_wdata(bound_wdata), .idx(repl_idx)
  );

  vxt_entry_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst(rst), .inv_all(inv_all),
    .load_en(load_en), .load_idx(repl_idx), .load_ent(load_ent),
    .lk_vpn(req_vaddr[VA_W-1:PG_LSB]), .lk_asid(cur_asid),
    .lk_skip_asid(req_sv && req_priv),
    .hit_any(hit_any), .hit_multi(hit_multi), .hit_ent(hit_ent)
  );

  vxt_fault_eval u_eval (
    .hit_any(hit_any), .hit_multi(hit_multi),
    .sz({hit_ent.flags[FB_SZ_HI], hit_ent.flags[FB_SZ_LO]}),
    .f_user(hit_ent.flags[FB_USER]), .f_wr(hit_ent.flags[FB_WR]),
    .f_dirty(hit_ent.flags[FB_DIRTY]), .ppn(hit_ent.ppn),
    .vaddr(req_vaddr), .priv(req_priv), .write(req_write),
    .fault(flt), .paddr(pa)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_hi_q    <= '0;
      stg_lo_q    <= '0;
      rsp_valid   <= 1'b0;
      rsp_paddr   <= '0;
      rsp_fault   <= '0;
      fault_vaddr <= '0;
    end else begin
      if (stg_hi_we) stg_hi_q <= stg_wdata & HI_KEEP;
      if (stg_lo_we) stg_lo_q <= stg_wdata & LO_KEEP;
      rsp_valid <= req_valid;
      rsp_fault <= req_valid ? flt : '0;
      rsp_paddr <= req_valid ? pa : '0;
      if (req_valid && flt != '0) begin
        fault_vaddr <= req_vaddr;
        stg_hi_q[VA_W-1:PG_LSB] <= req_vaddr[VA_W-1:PG_LSB];
      end
    end
  end

  assign stage_hi = stg_hi_q;

  // R12: never more than one fault flag in a response
  a_r12_fault_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rsp_fault));
  // R12: a faulting response carries no physical address
  a_r12_fault_no_pa: assert property (@(posedge clk) disable iff (rst)
    (rsp_fault != '0) |-> (rsp_paddr == '0 && rsp_valid));
  // R11: captured address and staged page number agree after a fault
  a_r11_capture_sync: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != '0) |-> (fault_vaddr[31:10] == stg_hi_q[31:10]));
endmodule

// File: tb/tb_utlb_xlate.sv
module tb_utlb_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inv_all = 0, stg_hi_we = 0, stg_lo_we = 0, load_en = 0, bound_we = 0;
  logic [31:0] stg_wdata = '0;
  logic [5:0]  bound_wdata = '0;
  logic        req_valid = 0, req_priv = 0, req_write = 0, req_sv = 0;
  logic [31:0] req_vaddr = '0;
  logic [7:0]  cur_asid = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr, fault_vaddr, stage_hi;
  logic [5:0]  rsp_fault, repl_idx;

  int n_chk = 0, n_bad = 0;
  int mctr = 0, mbound = 0;

  localparam logic [5:0] F_OK = 6'h00, F_RDM = 6'h01, F_WRM = 6'h02, F_MUL = 6'h04,
                         F_RDP = 6'h08, F_WRP = 6'h10, F_FW = 6'h20;

  always #4 clk = ~clk;  // 8 ns period, 125 MHz

  utlb_xlate dut (
    .clk(clk), .rst(rst), .inv_all(inv_all), .stg_hi_we(stg_hi_we), .stg_lo_we(stg_lo_we),
    .stg_wdata(stg_wdata), .load_en(load_en), .bound_we(bound_we), .bound_wdata(bound_wdata),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_priv(req_priv), .req_write(req_write),
    .req_sv(req_sv), .cur_asid(cur_asid), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .fault_vaddr(fault_vaddr), .repl_idx(repl_idx), .stage_hi(stage_hi)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_hi(input logic [31:0] v);
    stg_hi_we = 1; stg_wdata = v; @(negedge clk); stg_hi_we = 0;
  endtask
  task automatic write_lo(input logic [31:0] v);
    stg_lo_we = 1; stg_wdata = v; @(negedge clk); stg_lo_we = 0;
  endtask
  task automatic set_bound(input int b);
    bound_we = 1; bound_wdata = 6'(b); @(negedge clk); bound_we = 0; mbound = b;
  endtask

  // one lookup; outputs are valid when this returns
  task automatic lookup(input logic [31:0] va, input logic pv, input logic wr,
                        input logic sv, input logic [7:0] asid);
    req_valid = 1; req_vaddr = va; req_priv = pv; req_write = wr; req_sv = sv; cur_asid = asid;
    @(negedge clk);
    req_valid = 0;
    mctr = (mctr + 1 == mbound || mctr + 1 == 64) ? 0 : mctr + 1;
  endtask

  task automatic expect_rsp(input string tag, input logic [5:0] f, input logic [31:0] pa);
    chk(tag, {25'd0, rsp_valid, rsp_fault, rsp_paddr}, {25'd0, 1'b1, f, pa});
  endtask

  // load an entry, then advance the counter with a throw-away lookup
  task automatic install(input logic [31:0] hi, input logic [31:0] lo);
    write_hi(hi); write_lo(lo);
    load_en = 1; @(negedge clk); load_en = 0;
    lookup(32'hF000_0000, 1'b1, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic t_reset();
    chk("R12 reset rsp", {rsp_valid, rsp_fault, rsp_paddr}, '0);
    chk("R10 reset counter", 64'(repl_idx), 0);
    chk("R11 reset capture", {stage_hi, fault_vaddr}, '0);
  endtask

  task automatic t_miss_capture();
    write_hi(32'h0000_035A);
    lookup(32'h1357_9BDF, 1'b1, 1'b0, 1'b0, 8'h5A);
    expect_rsp("R4 read miss", F_RDM, 0);
    chk("R11 fault addr", 64'(fault_vaddr), 64'h1357_9BDF);
    chk("R11 staged page", 64'(stage_hi), 64'h1357_985A);
    lookup(32'h2000_0004, 1'b0, 1'b1, 1'b0, 8'h5A);
    expect_rsp("R4 write miss", F_WRM, 0);
    chk("R11 fault addr wr", 64'(fault_vaddr), 64'h2000_0004);
    @(negedge clk);
    chk("R12 strobe one cycle", 64'(rsp_valid), 0);
  endtask

  task automatic t_fill();
    install(32'h0040_0011, 32'h0ABC_D374);  // 4K, user, writable, dirty
    install(32'h1230_0033, 32'hE560_01B6);  // 1M, shared, writable, dirty, supervisor only
    install(32'h7FFF_0011, 32'h1FFF_01E0);  // 64K, user, writable, clean
    install(32'h0000_2411, 32'h0000_0D44);  // 1K, user, dirty, read-only
  endtask

  task automatic t_sizes();
    lookup(32'h0040_0ABC, 1'b0, 1'b0, 1'b0, 8'h11);
    expect_rsp("R1 4K page", F_OK, 32'h0ABC_DABC);
    lookup(32'h123F_FFF0, 1'b1, 1'b0, 1'b0, 8'h77);
    expect_rsp("R1 R9 1M page", F_OK, 32'h056F_FFF0);
    lookup(32'h7FFF_1234, 1'b0, 1'b0, 1'b0, 8'h11);
    expect_rsp("R1 64K page", F_OK, 32'h1FFF_1234);
    lookup(32'h0000_27FF, 1'b0, 1'b0, 1'b0, 8'h11);
    expect_rsp("R1 1K page", F_OK, 32'h0000_0FFF);
    lookup(32'h0000_2800, 1'b0, 1'b0, 1'b0, 8'h11);
    expect_rsp("R1 1K bound", F_RDM, 0);
    chk("R11 no update on hit", 64'(fault_vaddr), 64'h0000_2800);
  endtask

  task automatic t_asid();
    lookup(32'h0040_0ABC, 1'b0, 1'b0, 1'b0, 8'h22);
    expect_rsp("R2 asid mismatch", F_RDM, 0);
    lookup(32'h0040_0ABC, 1'b1, 1'b0, 1'b1, 8'h22);
    expect_rsp("R3 sv priv bypass", F_OK, 32'h0ABC_DABC);
    lookup(32'h0040_0ABC, 1'b0, 1'b0, 1'b1, 8'h22);
    expect_rsp("R3 sv user no bypass", F_RDM, 0);
    lookup(32'h0040_0ABC, 1'b1, 1'b0, 1'b0, 8'h22);
    expect_rsp("R3 priv no sv", F_RDM, 0);
    lookup(32'h1230_0000, 1'b1, 1'b0, 1'b0, 8'hC4);
    expect_rsp("R2 shared page", F_OK, 32'h0560_0000);
  endtask

  task automatic t_protect();
    lookup(32'h123F_FFF0, 1'b0, 1'b0, 1'b0, 8'h77);
    expect_rsp("R6 user read prot", F_RDP, 0);
    lookup(32'h123F_FFF0, 1'b0, 1'b1, 1'b0, 8'h77);
    expect_rsp("R7 user write no user flag", F_WRP, 0);
    lookup(32'h123F_FFF0, 1'b1, 1'b1, 1'b0, 8'h77);
    expect_rsp("R7 priv write ok", F_OK, 32'h056F_FFF0);
    lookup(32'h0000_27FF, 1'b1, 1'b1, 1'b0, 8'h11);
    expect_rsp("R7 priv write read-only", F_WRP, 0);
    lookup(32'h0000_27FF, 1'b0, 1'b1, 1'b0, 8'h11);
    expect_rsp("R7 user write read-only", F_WRP, 0);
    lookup(32'h0040_0ABC, 1'b0, 1'b1, 1'b0, 8'h11);
    expect_rsp("R7 user write ok", F_OK, 32'h0ABC_DABC);
  endtask

  task automatic t_first_write();
    lookup(32'h7FFF_1234, 1'b1, 1'b1, 1'b0, 8'h11);
    expect_rsp("R8 priv clean page", F_FW, 0);
    lookup(32'h7FFF_1234, 1'b0, 1'b1, 1'b0, 8'h11);
    expect_rsp("R8 user clean page", F_FW, 0);
  endtask

  task automatic t_multi();
    install(32'h0040_0800, 32'h0000_0166);  // 1K shared overlap of the 4K page
    lookup(32'h0040_0ABC, 1'b0, 1'b0, 1'b0, 8'h11);
    expect_rsp("R5 multi hit", F_MUL, 0);
    chk("R11 staged after multi", 64'(stage_hi), 64'h0040_0800);
    lookup(32'h0040_0100, 1'b0, 1'b0, 1'b0, 8'h11);
    expect_rsp("R5 single hit outside overlap", F_OK, 32'h0ABC_D100);
  endtask

  task automatic t_stage_masks();
    write_hi(32'hFFFF_FFFF);
    chk("R9 staging high mask", 64'(stage_hi), 64'hFFFF_FCFF);
  endtask

  task automatic t_invalidate();
    inv_all = 1; @(negedge clk); inv_all = 0;
    lookup(32'h123F_FFF0, 1'b1, 1'b0, 1'b0, 8'h33);
    expect_rsp("R13 invalidated", F_RDM, 0);
  endtask

  task automatic t_counter();
    chk("R10 counter track", 64'(repl_idx), 64'(mctr));
    set_bound(0);
    for (int i = 0; i < 70; i++) begin
      lookup(32'hF000_0000, 1'b1, 1'b0, 1'b0, 8'h00);
      chk("R10 wrap at entry count", 64'(repl_idx), 64'(mctr));
    end
    set_bound(3);
    for (int i = 0; i < 70; i++) begin
      lookup(32'hF000_0000, 1'b1, 1'b0, 1'b0, 8'h00);
      chk("R10 wrap at boundary", 64'(repl_idx), 64'(mctr));
    end
    chk("R10 counter below boundary", 64'(repl_idx < 3), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_miss_capture();
    t_fill();
    t_sizes();
    t_asid();
    t_protect();
    t_first_write();
    t_multi();
    t_stage_masks();
    t_invalidate();
    t_counter();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule